// File: doc/BRIEF.md
# Transport Stream Clock-Crossing FIFO

This block moves a byte-wide MPEG-2 transport stream from a writer clock domain into a reader clock domain. It uses a circular store of 128 entries. Each entry holds one data byte and three side-band bits. The first side-band bit marks the packet sync byte. The second carries the writer's error flag. The third carries a sequence-start marker. A byte is written only in writer cycles where the valid strobe is high. The gaps in a 204-cycle parallel frame (188 payload bytes, 16 idle check-byte slots) therefore take no space in the store.

On the reader side the block applies two rules to the stream:
- It folds the error flag into the most significant bit of the byte that follows each sync byte. That bit is the transport error indicator.
- It raises a start pulse together with the first sync byte written on or after a start request. If the start input is never raised, the start pulse never fires and downstream sequences run free.

Pointers cross the clock boundary as Gray code through two-flop synchronizers. Misuse of the store sets a sticky alarm in the domain where it happens:
- Writing while the store is full sets the overflow alarm.
- Reading while it is empty sets the underflow alarm.

Each alarm has its own clear input.

Top module: `ts_cdc_fifo`

## Requirements
- R1: The store holds exactly 128 entries: `full` stays low after 127 unread writes and is high after the 128th, and all 128 bytes are delivered afterwards in write order.
- R2: A byte is stored only on a `wr_clk` edge where `wr_valid` is high and `full` is low; stored bytes leave in the order written.
- R3: `rd_sync` is high on exactly those output beats whose byte was written with `wr_sync` high.
- R4: On the beat following a sync-marked beat, `rd_data[7]` equals the stored bit 7 ORed with the error bit of the sync byte and the error bit of that beat's own byte. All other beats carry their data unchanged, and their error bits have no effect.
- R5: A `wr_start` pulse attaches to the first sync-marked byte accepted in the same or a later `wr_clk` cycle. `rd_start` is high on that byte's output beat only, once per request.
- R6: If `wr_start` has never been high since reset, `rd_start` never goes high.
- R7: A write attempt while `full` is high is dropped and sets `ovf_alarm`. The alarm stays set until `ovf_clr` is sampled high in a cycle with no new overflow; a new overflow wins over a clear in the same cycle.
- R8: `rd_en` high while `empty` is high sets `udf_alarm` and produces no output beat. The alarm stays set until `udf_clr` is sampled high in a cycle with no new underflow.
- R9: `rd_valid` is high in the `rd_clk` cycle after an edge that samples `rd_en` high and `empty` low, and is low otherwise; `rd_data`, `rd_sync` and `rd_start` are valid with it.
- R10: After reset, `empty` is high, `full` is low, both alarms are low and `rd_valid` is low.
- R11: A 204-cycle frame with `wr_valid` low for its last 16 cycles delivers exactly 188 bytes per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| wr_rst | input | 1 | Writer-domain synchronous reset, active high |
| wr_valid | input | 1 | Byte strobe; a byte is written only when high |
| wr_data | input | 8 | Transport stream byte |
| wr_sync | input | 1 | Marks this byte as a packet sync byte |
| wr_err | input | 1 | Error flag travelling with this byte |
| wr_start | input | 1 | Sequence-start request |
| ovf_clr | input | 1 | Clears the overflow alarm |
| full | output | 1 | Store full, writer domain |
| ovf_alarm | output | 1 | Sticky write-while-full alarm |
| rd_clk | input | 1 | Reader clock |
| rd_rst | input | 1 | Reader-domain synchronous reset, active high |
| rd_en | input | 1 | Read request |
| udf_clr | input | 1 | Clears the underflow alarm |
| rd_valid | output | 1 | Output beat valid |
| rd_data | output | 8 | Output byte, error indicator merged |
| rd_sync | output | 1 | Output beat is a sync byte |
| rd_start | output | 1 | Sequence-start pulse aligned to a sync byte |
| empty | output | 1 | Store empty, reader domain |
| udf_alarm | output | 1 | Sticky read-while-empty alarm |

## Verification
The timing of each result is as follows:
- An output beat appears one `rd_clk` edge after the edge that samples the read request, so the R9 checks sample on the falling edge that follows.
- `full` and `ovf_alarm` change on the `wr_clk` edge that takes the write, and are checked on the next falling edge of `wr_clk`.
- A new entry reaches `empty` only after the two-flop synchronizer, which takes two to three reader edges. The bench therefore polls `empty` on falling edges before it times a single read.

The stream checks do not depend on this latency. A scoreboard queue is filled by the driver as each write is accepted, and the monitor pops an entry only on a beat where `rd_valid` is high.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

    // One store entry: payload byte plus side-band bits
    typedef struct packed {
        logic       start;   // sequence-start marker
        logic       err;     // error flag of this byte
        logic       sync;    // packet sync position
        logic [7:0] data;
    } ts_entry_t;

    // Fold the packet error flag into the transport error indicator bit
    function automatic logic [7:0] tei_merge(input logic [7:0] d,
                                             input logic       after_sync,
                                             input logic       sync_err,
                                             input logic       own_err);
        logic [7:0] r;
        r    = d;
        r[7] = d[7] | (after_sync & (sync_err | own_err));
        return r;
    endfunction

endpackage

// File: rtl/tsx_sync2.sv
module tsx_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/tsx_store.sv
module tsx_store
    import tsx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  ts_entry_t         wentry,
    input  logic [ADDR_W-1:0] raddr,
    output ts_entry_t         rentry
);
    localparam int DEPTH = 1 << ADDR_W;

    ts_entry_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wentry;
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/tsx_wr_side.sv
module tsx_wr_side
    import tsx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [7:0]        data,
    input  logic              sync,
    input  logic              err,
    input  logic              start,
    input  logic              alarm_clr,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              full,
    output logic              alarm,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output ts_entry_t         wentry,
    output logic [ADDR_W:0]   wr_gray
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] bin_q, bin_nx, gray_q;
    logic          pend_q;
    logic          accept;
    logic          start_hit;

    assign full      = (gray_q == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
    assign accept    = valid & ~full;
    assign bin_nx    = bin_q + PW'(1);
    assign start_hit = sync & (pend_q | start);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
            pend_q <= 1'b0;
            alarm  <= 1'b0;
        end else begin
            if (accept) begin
                bin_q  <= bin_nx;
                gray_q <= bin_nx ^ (bin_nx >> 1);
            end
            pend_q <= (pend_q | start) & ~(accept & sync);
            if (valid && full)  alarm <= 1'b1;
            else if (alarm_clr) alarm <= 1'b0;
        end
    end

    assign we      = accept;
    assign waddr   = bin_q[ADDR_W-1:0];
    assign wentry  = '{start: start_hit, err: err, sync: sync, data: data};
    assign wr_gray = gray_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (valid && full) |=> $stable(bin_q)) else $error("overflow write advanced pointer"); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (alarm && !alarm_clr) |=> alarm) else $error("overflow alarm dropped"); // R7
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (valid && full) |=> alarm) else $error("overflow alarm not set"); // R7
    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gray_q ^ $past(gray_q))) else $error("write gray pointer jumped"); // R1
endmodule

// File: rtl/tsx_rd_side.sv
module tsx_rd_side
    import tsx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              alarm_clr,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  ts_entry_t         rentry,
    output logic [ADDR_W-1:0] raddr,
    output logic              empty,
    output logic              alarm,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sync,
    output logic              out_start,
    output logic [ADDR_W:0]   rd_gray
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] bin_q, bin_nx, gray_q;
    logic          after_sync_q;
    logic          sync_err_q;
    logic          take;

    assign empty  = (gray_q == wr_gray_s);
    assign take   = rd_en & ~empty;
    assign bin_nx = bin_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q        <= '0;
            gray_q       <= '0;
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_sync     <= 1'b0;
            out_start    <= 1'b0;
            after_sync_q <= 1'b0;
            sync_err_q   <= 1'b0;
            alarm        <= 1'b0;
        end else begin
            out_valid <= take;
            out_sync  <= take & rentry.sync;
            out_start <= take & rentry.start;
            if (take) begin
                bin_q        <= bin_nx;
                gray_q       <= bin_nx ^ (bin_nx >> 1);
                out_data     <= tei_merge(rentry.data, after_sync_q, sync_err_q, rentry.err);
                after_sync_q <= rentry.sync;
                sync_err_q   <= rentry.err;
            end
            if (rd_en && empty) alarm <= 1'b1;
            else if (alarm_clr) alarm <= 1'b0;
        end
    end

    assign raddr   = bin_q[ADDR_W-1:0];
    assign rd_gray = gray_q;

    AST_EMPTY_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        empty |=> !out_valid) else $error("beat produced from empty store"); // R9
    AST_UDF_SET: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> alarm) else $error("underflow alarm not set"); // R8
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (alarm && !alarm_clr) |=> alarm) else $error("underflow alarm dropped"); // R8
    AST_START_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
        out_start |-> (out_sync && out_valid)) else $error("start pulse off a sync beat"); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        empty |=> $stable(bin_q)) else $error("read pointer moved while empty"); // R8
endmodule

// File: rtl/ts_cdc_fifo.sv
module ts_cdc_fifo
    import tsx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_sync,
    input  logic       wr_err,
    input  logic       wr_start,
    input  logic       ovf_clr,
    output logic       full,
    output logic       ovf_alarm,
    input  logic       rd_clk,
    input  logic       rd_rst,
    input  logic       rd_en,
    input  logic       udf_clr,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_sync,
    output logic       rd_start,
    output logic       empty,
    output logic       udf_alarm
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray, wr_gray_s, rd_gray, rd_gray_s;
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    ts_entry_t         wentry, rentry;

    tsx_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .valid(wr_valid), .data(wr_data),
        .sync(wr_sync), .err(wr_err), .start(wr_start), .alarm_clr(ovf_clr),
        .rd_gray_s(rd_gray_s), .full(full), .alarm(ovf_alarm), .we(we),
        .waddr(waddr), .wentry(wentry), .wr_gray(wr_gray)
    );

    tsx_store #(.ADDR_W(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wentry(wentry),
        .raddr(raddr), .rentry(rentry)
    );

    tsx_sync2 #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s)
    );

    tsx_sync2 #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s)
    );

    tsx_rd_side #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .alarm_clr(udf_clr),
        .wr_gray_s(wr_gray_s), .rentry(rentry), .raddr(raddr), .empty(empty),
        .alarm(udf_alarm), .out_valid(rd_valid), .out_data(rd_data),
        .out_sync(rd_sync), .out_start(rd_start), .rd_gray(rd_gray)
    );
endmodule

// File: tb/sim_ts_cdc_fifo.sv
`timescale 1ns/1ps
module sim_ts_cdc_fifo;
    logic       wr_clk = 0, rd_clk = 0;
    logic       wr_rst, rd_rst;
    logic       wr_valid, wr_sync, wr_err, wr_start, ovf_clr;
    logic [7:0] wr_data;
    logic       rd_en, udf_clr;
    logic       full, ovf_alarm, rd_valid, rd_sync, rd_start, empty, udf_alarm;
    logic [7:0] rd_data;

    always #2.5 rd_clk = ~rd_clk;   // 200 MHz
    always #3.5 wr_clk = ~wr_clk;

    ts_cdc_fifo u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_sync(wr_sync), .wr_err(wr_err), .wr_start(wr_start), .ovf_clr(ovf_clr),
        .full(full), .ovf_alarm(ovf_alarm), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_en(rd_en), .udf_clr(udf_clr), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sync(rd_sync), .rd_start(rd_start), .empty(empty), .udf_alarm(udf_alarm)
    );

    typedef struct {
        logic [7:0] d;
        logic       s;
        logic       st;
        logic       tei;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0, n_rx = 0, n_start = 0;
    bit   done = 0;
    bit   m_pend = 0, m_after = 0, m_serr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: present one byte, predict acceptance and push expected beat
    task automatic put(input logic [7:0] d, input logic s, input logic e, input logic st);
        exp_t x;
        bit   acc;
        @(negedge wr_clk);
        wr_valid = 1; wr_data = d; wr_sync = s; wr_err = e; wr_start = st;
        acc = !full;
        if (acc) begin
            x.d   = d;
            x.tei = 0;
            if (m_after && (m_serr || e)) begin
                x.d[7] = 1'b1;
                x.tei  = 1;
            end
            x.s  = s;
            x.st = s && (m_pend || st);
            q.push_back(x);
            m_after = s;
            m_serr  = e;
        end
        m_pend = (m_pend || st) && !(acc && s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_valid = 0; wr_sync = 0; wr_err = 0; wr_start = 0;
        end
    endtask

    // Monitor: pop and compare on every output beat
    always @(negedge rd_clk) begin
        exp_t e;
        if (!rd_rst && rd_valid) begin
            n_rx++;
            if (rd_start) n_start++;
            if (q.size() == 0) begin
                chk(0, "R2", "unexpected beat", n_rx, 0);
            end else begin
                e = q.pop_front();
                chk(rd_data == e.d, e.tei ? "R4" : "R2", "data", rd_data, e.d);
                chk(rd_sync == e.s, "R3", "sync flag", rd_sync, e.s);
                chk(rd_start == e.st, e.st ? "R5" : "R6", "start pulse", rd_start, e.st);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge rd_clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rx0;
        wr_rst = 1; rd_rst = 1;
        wr_valid = 0; wr_sync = 0; wr_err = 0; wr_start = 0; wr_data = 0; ovf_clr = 0;
        rd_en = 0; udf_clr = 0;
        repeat (6) @(posedge wr_clk);
        @(negedge wr_clk) wr_rst = 0;
        @(negedge rd_clk) rd_rst = 0;
        @(negedge rd_clk);
        chk(empty == 1, "R10", "empty after reset", empty, 1);
        chk(full == 0, "R10", "full after reset", full, 0);
        chk(ovf_alarm == 0 && udf_alarm == 0, "R10", "alarms after reset", ovf_alarm | udf_alarm, 0);
        chk(rd_valid == 0, "R10", "rd_valid after reset", rd_valid, 0);

        // R11 / R4 / R5 / R6: three 204-cycle frames, 16 idle slots each
        rd_en = 1;
        for (int f = 0; f < 3; f++) begin
            for (int c = 0; c < 204; c++) begin
                if (c < 188)
                    put(c == 0 ? 8'h47 : 8'((f * 31 + c * 7) & 8'h7f),
                        c == 0,
                        (f == 1 && c == 0) || (f == 2 && c == 1) || (f == 0 && c == 50),
                        f == 0 && c == 100);
                else
                    idle(1);
            end
        end
        idle(1);
        repeat (60) @(negedge rd_clk);
        chk(n_rx == 3 * 188, "R11", "bytes per three frames", n_rx, 3 * 188);
        chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
        chk(n_start == 1, "R5", "start pulses", n_start, 1);
        chk(udf_alarm == 1, "R8", "underflow alarm after gaps", udf_alarm, 1);

        // R8: clear, then a single read from the empty store
        rd_en = 0; udf_clr = 1;
        @(negedge rd_clk) udf_clr = 0;
        chk(udf_alarm == 0, "R8", "underflow alarm cleared", udf_alarm, 0);
        repeat (5) @(negedge rd_clk);
        chk(udf_alarm == 0, "R8", "alarm stays clear", udf_alarm, 0);
        rd_en = 1;
        @(negedge rd_clk) rd_en = 0;
        chk(udf_alarm == 1, "R8", "underflow alarm set", udf_alarm, 1);
        chk(rd_valid == 0, "R8", "no beat on underflow", rd_valid, 0);
        udf_clr = 1;
        @(negedge rd_clk) udf_clr = 0;

        // R1 / R7: fill without reading
        rx0 = n_rx;
        for (int i = 0; i < 127; i++) put(8'(i + 3), 0, 1, 0);
        idle(1);
        chk(full == 0, "R1", "full after 127 writes", full, 0);
        put(8'hA5, 0, 0, 0);
        idle(1);
        chk(full == 1, "R1", "full after 128 writes", full, 1);
        chk(ovf_alarm == 0, "R7", "no alarm before overflow", ovf_alarm, 0);
        put(8'hEE, 0, 0, 0);
        idle(1);
        chk(ovf_alarm == 1, "R7", "overflow alarm set", ovf_alarm, 1);
        @(negedge wr_clk) ovf_clr = 1;
        @(negedge wr_clk) ovf_clr = 0;
        chk(ovf_alarm == 0, "R7", "overflow alarm cleared", ovf_alarm, 0);
        @(negedge wr_clk) begin wr_valid = 1; wr_data = 8'h11; ovf_clr = 1; end
        @(negedge wr_clk) begin wr_valid = 0; ovf_clr = 0; end
        chk(ovf_alarm == 1, "R7", "overflow wins over clear", ovf_alarm, 1);
        @(negedge wr_clk) ovf_clr = 1;
        @(negedge wr_clk) ovf_clr = 0;

        @(negedge rd_clk) rd_en = 1;
        repeat (200) @(negedge rd_clk);
        rd_en = 0;
        chk(n_rx - rx0 == 128, "R1", "bytes delivered from full store", n_rx - rx0, 128);
        chk(q.size() == 0, "R7", "dropped bytes absent", q.size(), 0);
        chk(empty == 1, "R1", "empty after drain", empty, 1);

        // R9: single byte, timed read
        put(8'h5A, 0, 0, 0);
        idle(1);
        for (int k = 0; k < 20 && empty; k++) @(negedge rd_clk);
        chk(empty == 0, "R9", "entry visible to reader", empty, 0);
        chk(rd_valid == 0, "R9", "no beat without rd_en", rd_valid, 0);
        rd_en = 1;
        @(negedge rd_clk) rd_en = 0;
        chk(rd_valid == 1, "R9", "beat one cycle after rd_en", rd_valid, 1);
        chk(rd_data == 8'h5A, "R9", "beat data", rd_data, 8'h5A);
        @(negedge rd_clk);
        chk(rd_valid == 0, "R9", "beat ends", rd_valid, 0);
        chk(q.size() == 0, "R2", "scoreboard empty at end", q.size(), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule